// File: doc/BRIEF.md
# Bus Error Capture Controller

This block sits beside a processor's external bus interface and watches for a bus-error input raised by system logic against the transfer that is in progress. When the error is recognised, the block records the physical address of the failing transfer and a description of that transfer in two 64-bit capture registers. Software reads these registers back through a one-bit index.

The block also counts the ready strobes that the failing transfer still owes. A single transfer owes one strobe and a burst owes four, and the error does not shorten the transfer. If machine-check reporting is enabled, the block raises a one-cycle exception request, tagged with vector 0x12, once the failed transfer has fully completed. Three conditions hold that request back: a locked sequence still in progress, an inquire-triggered writeback still in progress, and a halt or stop-grant low-power state.

The block also settles conflicts between the error input and the bus back-off and hold requests. It returns an acknowledge for each of back-off, hold and address-hold.

Top module: `buserr_capture_ctrl`

## Requirements
- R1: After reset both capture registers read as zero and `mce_req` is low.
- R2: A recognised error copies the current transfer's address into the address register, zero-extended above `PA_W`. It copies the transfer description into the type register: bits [CT_W-1:0] hold the cycle type, bit CT_W holds burst, bit CT_W+1 holds locked and bit CT_W+2 holds inquire-writeback, and all higher bits are zero. Both values are latched when the transfer starts.
- R3: `rd_data` shows the type register when `rd_idx` is 0 and the address register when `rd_idx` is 1. The read path is combinational.
- R4: With `mc_enable` high when the error is recognised, `mce_req` pulses for exactly one cycle. With no deferral active, the pulse is high in the second cycle after the clock edge that samples the transfer's last ready strobe. `mce_vec` reads 0x12 during the pulse and 0 otherwise.
- R5: With `mc_enable` low when the error is recognised, the registers are still captured but no request is raised.
- R6: A transfer is owed 1 ready strobe when `cyc_burst` is 0 and 4 when it is 1. An error flagged on an early beat raises no request before the last of these strobes.
- R7: While `bus_lock` is high, a pending request is withheld. It is issued one cycle after the first edge that samples `bus_lock` low.
- R8: While `inq_wb` is high, a pending request is withheld in the same way.
- R9: While `low_power` is high, an error is recognised only together with `ready`, and a pending request is withheld until `low_power` is low.
- R10: If `backoff_req` and `bus_err` are both high and the error was not already being held, back-off is acknowledged and the error is ignored. The transfer is aborted, nothing is captured and no request follows.
- R11: While the error is held high after being recognised, `backoff_ack` stays low. While the error is effective, `hold_ack` stays low. `addr_hold_ack` always follows `addr_hold_req`.
- R12: An error raised while no transfer is outstanding is ignored and leaves the capture registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | New transfer begins (ignored while one is outstanding) |
| cyc_addr | input | PA_W | Physical address of the new transfer |
| cyc_type | input | CT_W | Cycle type code of the new transfer |
| cyc_burst | input | 1 | New transfer is a four-beat burst |
| bus_lock | input | 1 | Locked sequence in progress |
| inq_wb | input | 1 | Inquire-triggered writeback in progress |
| ready | input | 1 | Ready strobe for one beat |
| bus_err | input | 1 | Bus error raised by system logic |
| backoff_req | input | 1 | Back-off request |
| hold_req | input | 1 | Bus hold request |
| addr_hold_req | input | 1 | Address-hold request |
| low_power | input | 1 | Halt or stop-grant state |
| mc_enable | input | 1 | Machine-check reporting enable |
| rd_idx | input | 1 | Capture register select |
| rd_data | output | 64 | Selected capture register |
| mce_req | output | 1 | One-cycle machine-check exception request |
| mce_vec | output | 8 | Exception vector during the request |
| backoff_ack | output | 1 | Back-off recognised |
| hold_ack | output | 1 | Hold recognised |
| addr_hold_ack | output | 1 | Address-hold recognised |

## Verification
The hardest cases to reach combine an error on an early beat of a burst with a deferral that outlasts the transfer. One such case keeps `bus_lock` or `low_power` high for several cycles after the last strobe, and the request must appear only after the deferral drops. The bench builds these cases directly. It starts a burst, raises the error with the first strobe, and leaves gap cycles between strobes. Only then does it release the deferral input. A behavioural model tracks owed strobes and pending state with plain integers and is compared every cycle. Directed checks also count pulses across each of these windows.

// File: rtl/buserr_pkg.sv
package buserr_pkg;

   typedef enum logic {
      SEL_TYPE = 1'b0,
      SEL_ADDR = 1'b1
   } cap_sel_e;

   localparam int unsigned CAP_W = 64;

   function automatic int unsigned def_width(input int unsigned ct_w);
      return ct_w + 3;
   endfunction

endpackage

// File: rtl/buserr_cycle_trk.sv
module buserr_cycle_trk #(
   parameter int unsigned PA_W      = 32,
   parameter int unsigned CT_W      = 8,
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned DEF_W    = CT_W + 3,
   localparam int unsigned CNT_W    = $clog2(BURST_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_start,
   input  logic [PA_W-1:0]  cyc_addr,
   input  logic [CT_W-1:0]  cyc_type,
   input  logic             cyc_burst,
   input  logic             bus_lock,
   input  logic             inq_wb,
   input  logic             ready,
   input  logic             abort,
   output logic             active,
   output logic             last_beat,
   output logic [PA_W-1:0]  cur_addr,
   output logic [DEF_W-1:0] cur_def
);

   localparam logic [CNT_W-1:0] BEATS_BURST  = CNT_W'(BURST_LEN);
   localparam logic [CNT_W-1:0] BEATS_SINGLE = CNT_W'(1);

   logic [CNT_W-1:0] owed_q;
   logic [CNT_W-1:0] owed_new;

   generate
      if (BURST_LEN < 1) begin : g_bad_len
         $error("BURST_LEN must be at least one");
      end
      if (BURST_LEN == 1) begin : g_single_only
         assign owed_new = BEATS_SINGLE;
      end else begin : g_sel_len
         assign owed_new = cyc_burst ? BEATS_BURST : BEATS_SINGLE;
      end
   endgenerate

   assign active    = (owed_q != '0);
   assign last_beat = active & ready & (owed_q == BEATS_SINGLE) & ~abort;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owed_q   <= '0;
         cur_addr <= '0;
         cur_def  <= '0;
      end else if (abort) begin
         owed_q <= '0;
      end else if (!active && cyc_start) begin
         owed_q   <= owed_new;
         cur_addr <= cyc_addr;
         cur_def  <= {inq_wb, bus_lock, cyc_burst, cyc_type};
      end else if (active && ready) begin
         owed_q <= owed_q - CNT_W'(1);
      end
   end

   // R6: the owed count never exceeds the burst length
   a_r6_owed_bound: assert property (@(posedge clk) disable iff (!rst_n)
      owed_q <= BEATS_BURST);

   // R6: a transfer only ends after a strobe was seen
   a_r6_end_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !ready && !abort) |=> active);

endmodule

// File: rtl/buserr_arbiter.sv
module buserr_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_err,
   input  logic backoff_req,
   input  logic hold_req,
   input  logic addr_hold_req,
   output logic err_eff,
   output logic backoff_ack,
   output logic hold_ack,
   output logic addr_hold_ack
);

   logic err_held_q;

   assign backoff_ack   = backoff_req & ~(bus_err & err_held_q);
   assign err_eff       = bus_err & ~backoff_ack;
   assign hold_ack      = hold_req & ~err_eff;
   assign addr_hold_ack = addr_hold_req;

   always_ff @(posedge clk) begin
      if (!rst_n) err_held_q <= 1'b0;
      else        err_held_q <= err_eff;
   end

   // R11: an error kept high after it took effect blocks back-off
   a_r11_backoff_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && $past(bus_err) && !$past(backoff_ack)) |-> !backoff_ack);

   // R10: a fresh error never outranks back-off
   a_r10_backoff_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (backoff_req && !$past(bus_err)) |-> backoff_ack);

endmodule

// File: rtl/buserr_capture_regs.sv
module buserr_capture_regs
   import buserr_pkg::*;
#(
   parameter int unsigned PA_W = 32,
   parameter int unsigned CT_W = 8,
   localparam int unsigned DEF_W = CT_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [PA_W-1:0]  addr_in,
   input  logic [DEF_W-1:0] def_in,
   input  logic             rd_idx,
   output logic [CAP_W-1:0] rd_data
);

   logic [CAP_W-1:0] addr_q;
   logic [CAP_W-1:0] type_q;
   logic [CAP_W-1:0] addr_ext;
   logic [CAP_W-1:0] def_ext;

   generate
      if (PA_W > CAP_W || PA_W < 1) begin : g_bad_pa
         $error("PA_W must lie between 1 and 64");
      end
      if (DEF_W > CAP_W) begin : g_bad_ct
         $error("CT_W too wide for the type register");
      end
      if (PA_W == CAP_W) begin : g_addr_full
         assign addr_ext = addr_in;
      end else begin : g_addr_pad
         assign addr_ext = {{(CAP_W - PA_W){1'b0}}, addr_in};
      end
      if (DEF_W == CAP_W) begin : g_def_full
         assign def_ext = def_in;
      end else begin : g_def_pad
         assign def_ext = {{(CAP_W - DEF_W){1'b0}}, def_in};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         type_q <= '0;
      end else if (capture) begin
         addr_q <= addr_ext;
         type_q <= def_ext;
      end
   end

   always_comb begin
      unique case (cap_sel_e'(rd_idx))
         SEL_ADDR: rd_data = addr_q;
         default:  rd_data = type_q;
      endcase
   end

   // R12: without a capture strobe the registers keep their value
   a_r12_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(addr_q) && $stable(type_q)));

   generate
      if (PA_W < CAP_W) begin : g_chk_pad
         // R2: address bits above the physical width stay zero
         a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            addr_q[CAP_W-1:PA_W] == '0);
      end
   endgenerate

endmodule

// File: rtl/buserr_mce_sched.sv
module buserr_mce_sched (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic mc_enable,
   input  logic last_beat,
   input  logic abort,
   input  logic defer,
   output logic flagged,
   output logic mce_req
);

   logic flag_q;
   logic arm_q;
   logic pend_q;
   logic req_q;
   logic set_pend;
   logic fire;

   assign flagged  = flag_q;
   assign mce_req  = req_q;
   assign set_pend = last_beat & (arm_q | (hit & mc_enable));
   assign fire     = pend_q & ~defer & ~req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else if (abort || last_beat) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         flag_q <= flag_q | hit;
         arm_q  <= arm_q | (hit & mc_enable);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~fire) | set_pend;
         req_q  <= fire;
      end
   end

   // R4: the request is a single-cycle pulse
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mce_req |=> !mce_req);

   // R6: a request only becomes pending at the last strobe
   a_r6_pend_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(last_beat));

   // R7: a deferral input suppresses the next request
   a_r7_deferred: assert property (@(posedge clk) disable iff (!rst_n)
      defer |=> !mce_req);

endmodule

// File: rtl/buserr_capture_ctrl.sv
module buserr_capture_ctrl
   import buserr_pkg::*;
#(
   parameter int unsigned PA_W      = 32,
   parameter int unsigned CT_W      = 8,
   parameter int unsigned BURST_LEN = 4,
   parameter logic [7:0]  MC_VECTOR = 8'h12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cyc_start,
   input  logic [PA_W-1:0] cyc_addr,
   input  logic [CT_W-1:0] cyc_type,
   input  logic            cyc_burst,
   input  logic            bus_lock,
   input  logic            inq_wb,
   input  logic            ready,
   input  logic            bus_err,
   input  logic            backoff_req,
   input  logic            hold_req,
   input  logic            addr_hold_req,
   input  logic            low_power,
   input  logic            mc_enable,
   input  logic            rd_idx,
   output logic [63:0]     rd_data,
   output logic            mce_req,
   output logic [7:0]      mce_vec,
   output logic            backoff_ack,
   output logic            hold_ack,
   output logic            addr_hold_ack
);

   localparam int unsigned DEF_W = def_width(CT_W);

   logic             err_eff;
   logic             active;
   logic             last_beat;
   logic             flagged;
   logic             hit;
   logic             defer;
   logic [PA_W-1:0]  cur_addr;
   logic [DEF_W-1:0] cur_def;

   buserr_arbiter u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_err       (bus_err),
      .backoff_req   (backoff_req),
      .hold_req      (hold_req),
      .addr_hold_req (addr_hold_req),
      .err_eff       (err_eff),
      .backoff_ack   (backoff_ack),
      .hold_ack      (hold_ack),
      .addr_hold_ack (addr_hold_ack)
   );

   buserr_cycle_trk #(
      .PA_W      (PA_W),
      .CT_W      (CT_W),
      .BURST_LEN (BURST_LEN)
   ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (cyc_start),
      .cyc_addr  (cyc_addr),
      .cyc_type  (cyc_type),
      .cyc_burst (cyc_burst),
      .bus_lock  (bus_lock),
      .inq_wb    (inq_wb),
      .ready     (ready),
      .abort     (backoff_ack),
      .active    (active),
      .last_beat (last_beat),
      .cur_addr  (cur_addr),
      .cur_def   (cur_def)
   );

   assign hit   = err_eff & active & (~low_power | ready) & ~flagged;
   assign defer = bus_lock | inq_wb | low_power;

   buserr_capture_regs #(
      .PA_W (PA_W),
      .CT_W (CT_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (hit),
      .addr_in (cur_addr),
      .def_in  (cur_def),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   buserr_mce_sched u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .mc_enable (mc_enable),
      .last_beat (last_beat),
      .abort     (backoff_ack),
      .defer     (defer),
      .flagged   (flagged),
      .mce_req   (mce_req)
   );

   assign mce_vec = mce_req ? MC_VECTOR : 8'h00;

   // R12: no capture without an outstanding transfer
   a_r12_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !hit);

   // R11: an effective error always blocks hold
   a_r11_hold_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !backoff_req) |-> !hold_ack);

   // R4: vector present exactly with the request
   a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
      mce_req |-> (mce_vec == MC_VECTOR));

endmodule

// File: tb/buserr_capture_ctrl_tb.sv
module buserr_capture_ctrl_tb_top;

   localparam int PA_W = 32;
   localparam int CT_W = 8;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cyc_start, cyc_burst, bus_lock, inq_wb, ready, bus_err;
   logic            backoff_req, hold_req, addr_hold_req, low_power, mc_enable, rd_idx;
   logic [PA_W-1:0] cyc_addr;
   logic [CT_W-1:0] cyc_type;
   logic [63:0]     rd_data;
   logic            mce_req, backoff_ack, hold_ack, addr_hold_ack;
   logic [7:0]      mce_vec;

   int vectors = 0;
   int errors  = 0;
   int pulses  = 0;

   // behavioural reference state
   int          m_owed = 0;
   logic [63:0] m_addr = '0, m_def = '0, m_areg = '0, m_treg = '0;
   bit          m_flag = 0, m_arm = 0, m_pend = 0, m_req = 0, m_held = 0;

   always #2 clk = ~clk;

   buserr_capture_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
      .cyc_type(cyc_type), .cyc_burst(cyc_burst), .bus_lock(bus_lock),
      .inq_wb(inq_wb), .ready(ready), .bus_err(bus_err),
      .backoff_req(backoff_req), .hold_req(hold_req),
      .addr_hold_req(addr_hold_req), .low_power(low_power),
      .mc_enable(mc_enable), .rd_idx(rd_idx), .rd_data(rd_data),
      .mce_req(mce_req), .mce_vec(mce_vec), .backoff_ack(backoff_ack),
      .hold_ack(hold_ack), .addr_hold_ack(addr_hold_ack)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit exp_boff_ack();
      return backoff_req && !(bus_err && m_held);
   endfunction

   // reference update on each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_owed = 0; m_addr = '0; m_def = '0; m_areg = '0; m_treg = '0;
         m_flag = 0; m_arm = 0; m_pend = 0; m_req = 0; m_held = 0;
      end else begin
         bit ba, eff, act, hit, last, setp, fire;
         ba   = exp_boff_ack();
         eff  = bus_err && !ba;
         act  = (m_owed > 0);
         hit  = eff && act && (!low_power || ready) && !m_flag;
         last = act && ready && (m_owed == 1) && !ba;
         setp = last && (m_arm || (hit && mc_enable));
         fire = m_pend && !(bus_lock || inq_wb || low_power) && !m_req;
         if (hit) begin
            m_areg = m_addr;
            m_treg = m_def;
         end
         m_pend = (m_pend && !fire) || setp;
         m_req  = fire;
         m_held = eff;
         if (ba || last) begin
            m_flag = 0; m_arm = 0;
         end else begin
            m_flag = m_flag || hit;
            m_arm  = m_arm || (hit && mc_enable);
         end
         if (ba) m_owed = 0;
         else if (!act && cyc_start) begin
            m_owed = cyc_burst ? 4 : 1;
            m_addr = 64'(cyc_addr);
            m_def  = 64'({inq_wb, bus_lock, cyc_burst, cyc_type});
         end else if (act && ready) m_owed--;
      end
   end

   // compare every cycle, away from the edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4 mce_req", 64'(mce_req), 64'(m_req));
         chk("R4 mce_vec", 64'(mce_vec), m_req ? 64'h12 : 64'h0);
         chk("R3 rd_data", rd_data, rd_idx ? m_areg : m_treg);
         chk("R10 backoff_ack", 64'(backoff_ack), 64'(exp_boff_ack()));
         chk("R11 hold_ack", 64'(hold_ack),
             64'(hold_req && !(bus_err && !exp_boff_ack())));
         chk("R11 addr_hold_ack", 64'(addr_hold_ack), 64'(addr_hold_req));
         if (mce_req) pulses++;
      end
   end

   task automatic step(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic idle();
      cyc_start = 0; ready = 0; bus_err = 0; backoff_req = 0;
      hold_req = 0; addr_hold_req = 0;
   endtask

   task automatic begin_cycle(input logic [31:0] a, input logic [7:0] t, input bit burst);
      cyc_start = 1; cyc_addr = a; cyc_type = t; cyc_burst = burst;
      step();
      cyc_start = 0;
   endtask

   task automatic read_chk(input string tag, input bit idx, input logic [63:0] exp);
      rd_idx = idx;
      #0.5;
      chk(tag, rd_data, exp);
   endtask

   initial begin
      int base;
      rst_n = 0; cyc_addr = '0; cyc_type = '0; cyc_burst = 0; bus_lock = 0;
      inq_wb = 0; low_power = 0; mc_enable = 1; rd_idx = 0;
      idle();
      step(3);
      rst_n = 1;
      step();

      // R1: reset state
      read_chk("R1 type reg", 0, 64'h0);
      read_chk("R1 addr reg", 1, 64'h0);
      chk("R1 mce_req", 64'(mce_req), 64'h0);

      // R2 R3 R4: single transfer with error
      base = pulses;
      begin_cycle(32'hA000_1234, 8'h05, 0);
      ready = 1; bus_err = 1; step();
      idle(); step();
      chk("R4 pulse in second cycle", 64'(mce_req), 64'h1);
      step(3);
      chk("R4 one pulse", 64'(pulses - base), 64'h1);
      read_chk("R2 address captured", 1, 64'h0000_0000_A000_1234);
      read_chk("R3 type captured", 0, 64'h005);

      // R5: reporting disabled
      mc_enable = 0; base = pulses;
      begin_cycle(32'hB0B0_0008, 8'h21, 0);
      ready = 1; bus_err = 1; step();
      idle(); step(4);
      chk("R5 no request", 64'(pulses - base), 64'h0);
      read_chk("R5 still captured", 1, 64'h0000_0000_B0B0_0008);
      mc_enable = 1;

      // R6: burst, error on first beat, strobes with gaps
      base = pulses;
      begin_cycle(32'hC000_0040, 8'h33, 1);
      ready = 1; bus_err = 1; step();
      idle(); step();
      ready = 1; step(); idle(); step(2);
      ready = 1; step(); idle(); step(3);
      chk("R6 no request before last strobe", 64'(pulses - base), 64'h0);
      read_chk("R6 burst flag in type", 0, 64'h133);
      ready = 1; step(); idle(); step(3);
      chk("R6 request after fourth strobe", 64'(pulses - base), 64'h1);

      // R7: locked sequence defers the request
      base = pulses; bus_lock = 1;
      begin_cycle(32'hD000_0010, 8'h02, 0);
      ready = 1; bus_err = 1; step();
      idle(); step(5);
      chk("R7 withheld while locked", 64'(pulses - base), 64'h0);
      read_chk("R7 lock flag in type", 0, 64'h202);
      bus_lock = 0; step(3);
      chk("R7 issued after lock ends", 64'(pulses - base), 64'h1);

      // R8: inquire writeback defers the request
      base = pulses; inq_wb = 1;
      begin_cycle(32'hE000_0020, 8'h07, 1);
      ready = 1; bus_err = 1; step(); bus_err = 0;
      step(3); idle(); step(4);
      chk("R8 withheld during writeback", 64'(pulses - base), 64'h0);
      inq_wb = 0; step(3);
      chk("R8 issued after writeback", 64'(pulses - base), 64'h1);

      // R9: low power, error without strobe ignored
      base = pulses; low_power = 1;
      begin_cycle(32'h1111_0000, 8'h09, 0);
      bus_err = 1; step();
      bus_err = 0; ready = 1; step();
      idle(); step(2);
      read_chk("R9 error without strobe ignored", 1, 64'h0000_0000_E000_0020);
      begin_cycle(32'h2222_0000, 8'h0A, 0);
      ready = 1; bus_err = 1; step();
      idle(); step(5);
      read_chk("R9 error with strobe captured", 1, 64'h0000_0000_2222_0000);
      chk("R9 withheld in low power", 64'(pulses - base), 64'h0);
      low_power = 0; step(3);
      chk("R9 issued after wake", 64'(pulses - base), 64'h1);

      // R10: back-off and error together
      base = pulses;
      begin_cycle(32'h3333_0000, 8'h0B, 1);
      backoff_req = 1; bus_err = 1; #0.5;
      chk("R10 back-off acknowledged", 64'(backoff_ack), 64'h1);
      step(); idle();
      ready = 1; step(4); idle(); step(3);
      read_chk("R10 nothing captured", 1, 64'h0000_0000_2222_0000);
      chk("R10 no request", 64'(pulses - base), 64'h0);

      // R11: held error blocks back-off and hold, not address-hold
      base = pulses;
      begin_cycle(32'h4444_0000, 8'h0C, 1);
      bus_err = 1; step();
      backoff_req = 1; hold_req = 1; addr_hold_req = 1; #0.5;
      chk("R11 back-off blocked", 64'(backoff_ack), 64'h0);
      chk("R11 hold blocked", 64'(hold_ack), 64'h0);
      chk("R11 address-hold granted", 64'(addr_hold_ack), 64'h1);
      step(); idle();
      ready = 1; step(4); idle(); step(3);
      chk("R11 request after burst", 64'(pulses - base), 64'h1);
      read_chk("R11 capture kept", 1, 64'h0000_0000_4444_0000);

      // R12: error with no outstanding transfer
      base = pulses;
      bus_err = 1; step(2); idle(); step(3);
      read_chk("R12 idle error ignored", 1, 64'h0000_0000_4444_0000);
      chk("R12 no request", 64'(pulses - base), 64'h0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule